// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor load/store port and a word-addressed main memory. Each byte address is split into three fields: a word select inside the line, a set index, and a tag. The tag is compared against every way of the selected set at the same time. A match on a valid way answers in one cycle. A miss stalls the processor while the controller moves whole lines over a memory handshake that transfers one word per acknowledge.

Stores follow a write-back, write-allocate policy. A store hit changes only the cached copy and marks the line dirty. A store miss first brings the line in from memory and then merges the store bytes into it. Each set has one rotating replacement pointer, and the way it points at is the victim on a miss. A flush input clears the contents of the cache. Two counters report hits and misses, so the miss rate can be compared against a model.

Top module: `cache_ctrl`

## Requirements
- R1: With the default sizes, byte address bits [3:2] select the word in a 4-word line, bits [5:4] select one of 4 sets, and bits [15:6] form the tag; a load returns the 32-bit word held at that position.
- R2: All ways of the selected set are compared in parallel. A request that matches a valid way is a hit: cpu_ready is high in the cycle after the accepting clock edge, hit_count rises by one, and memory is not accessed.
- R3: An entry whose valid bit is clear never produces a hit, even when its stored tag equals the request tag; after reset the first access to address 0 misses.
- R4: On a miss, miss_count rises by one. The line is read from memory with mem_we low, starting at word 0 of the line and going up by one word address per mem_ack. It is then installed as valid and clean, and the request completes with one cpu_ready pulse.
- R5: A store that hits writes only the cached word and marks the line dirty; no memory write takes place.
- R6: When the victim is valid and dirty, all of its words are written to memory under its own tag (mem_we high) before any word of the new line is read. A clean or invalid victim causes no memory write. mem_req, mem_we and mem_addr hold steady while an acknowledge is pending.
- R7: A store that misses fetches the line first. It then replaces, for each cpu_be bit i, byte i (data bits 8i+7:8i) of the addressed word.
- R8: Each set has a pointer that starts at way 0. The pointer moves to the next way, wrapping to 0 after the last, whenever its way is hit or filled. On a miss the way under the pointer is replaced.
- R9: A flush pulse taken while no request is in progress clears every valid and dirty bit and every pointer. Dirty data is discarded without any memory write, and later accesses miss.
- R10: cpu_ready is a single-cycle pulse. A request held high during that pulse is not accepted a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate the whole cache when idle |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Request complete (one-cycle pulse) |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |
| mem_ack | input | 1 | One word transferred |
| hit_count | output | 32 | Number of hits since reset |
| miss_count | output | 32 | Number of misses since reset |

## Verification
The hardest case to reach is the eviction of a dirty victim chosen by the rotating pointer. It needs a line that was stored to, a pointer resting on that line's way, and a conflicting tag arriving in the same set. The random stimulus draws tags from only six values over four sets, and about half the operations are stores, so dirty conflicts come up often. A directed sequence in one set also walks the pointer through hit, fill and wraparound. The memory responder acknowledges after random delays, records whether any write-back word follows a fill read, and checks that fill addresses run upward from word 0.

// File: rtl/cache_ctrl.sv
module cache_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 4,
  parameter int WAYS       = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            cpu_req,
  input  logic                            cpu_we,
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic [WORD_W-1:0]               cpu_wdata,
  input  logic [WORD_W/8-1:0]             cpu_be,
  output logic [WORD_W-1:0]               cpu_rdata,
  output logic                            cpu_ready,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [ADDR_W-$clog2(WORD_W/8)-1:0] mem_addr,
  output logic [WORD_W-1:0]               mem_wdata,
  input  logic [WORD_W-1:0]               mem_rdata,
  input  logic                            mem_ack,
  output logic [31:0]                     hit_count,
  output logic [31:0]                     miss_count
);
  localparam int BE_W  = WORD_W / 8;
  localparam int BO_W  = $clog2(BE_W);
  localparam int WO_W  = $clog2(LINE_WORDS);
  localparam int IX_W  = $clog2(SETS);
  localparam int TAG_W = ADDR_W - BO_W - WO_W - IX_W;
  localparam int PW    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LINES = SETS * WAYS;

  typedef enum logic [1:0] {IDLE, WBACK, FILL, DONE} st_t;
  st_t state_q;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINES-1:0]  val_q, dty_q;
  logic [PW-1:0]     ptr_q [SETS];
  logic [WORD_W-1:0] dat_q [LINES*LINE_WORDS];
  logic [WO_W-1:0]   cnt_q;
  logic [PW-1:0]     vic_q;

  wire [WO_W-1:0]  a_word = cpu_addr[BO_W +: WO_W];
  wire [IX_W-1:0]  a_idx  = cpu_addr[BO_W+WO_W +: IX_W];
  wire [TAG_W-1:0] a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  logic unused_bits;
  assign unused_bits = ^cpu_addr[BO_W-1:0];

  logic [WAYS-1:0] hit_vec;
  logic [PW-1:0]   hit_way, acc_way;
  logic            hit;
  int              vline, aline, aent;

  always_comb begin
    hit_vec = '0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      int ln;
      ln = int'(a_idx) * WAYS + w;
      if (val_q[ln] && tag_q[ln] == a_tag) begin
        hit_vec[w] = 1'b1;
        hit_way    = PW'(w);
      end
    end
  end
  assign hit     = |hit_vec;
  assign acc_way = (state_q == DONE) ? vic_q : hit_way;

  always_comb begin
    vline = int'(a_idx) * WAYS + int'(vic_q);
    aline = int'(a_idx) * WAYS + int'(acc_way);
    aent  = aline * LINE_WORDS + int'(a_word);
  end

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(WAYS-1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old);
    logic [WORD_W-1:0] r;
    r = old;
    for (int b = 0; b < BE_W; b++)
      if (cpu_be[b]) r[8*b +: 8] = cpu_wdata[8*b +: 8];
    return r;
  endfunction

  assign mem_req   = (state_q == WBACK) || (state_q == FILL);
  assign mem_we    = (state_q == WBACK);
  assign mem_addr  = mem_we ? {tag_q[vline], a_idx, cnt_q} : {a_tag, a_idx, cnt_q};
  assign mem_wdata = dat_q[vline*LINE_WORDS + int'(cnt_q)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= IDLE;
      val_q      <= '0;
      dty_q      <= '0;
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      cnt_q      <= '0;
      vic_q      <= '0;
      cpu_ready  <= 1'b0;
      cpu_rdata  <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (state_q)
        IDLE: begin
          if (flush) begin
            val_q <= '0;
            dty_q <= '0;
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
          end else if (cpu_req && !cpu_ready) begin
            if (hit) begin
              hit_count <= hit_count + 32'd1;
              cpu_ready <= 1'b1;
              cpu_rdata <= dat_q[aent];
              if (cpu_we) begin
                dat_q[aent]  <= merge(dat_q[aent]);
                dty_q[aline] <= 1'b1;
              end
              if (hit_way == ptr_q[a_idx]) ptr_q[a_idx] <= nxt(hit_way);
            end else begin
              miss_count <= miss_count + 32'd1;
              vic_q      <= ptr_q[a_idx];
              cnt_q      <= '0;
              if (val_q[int'(a_idx)*WAYS + int'(ptr_q[a_idx])] &&
                  dty_q[int'(a_idx)*WAYS + int'(ptr_q[a_idx])])
                state_q <= WBACK;
              else
                state_q <= FILL;
            end
          end
        end
        WBACK: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == WO_W'(LINE_WORDS-1)) state_q <= FILL;
        end
        FILL: if (mem_ack) begin
          dat_q[vline*LINE_WORDS + int'(cnt_q)] <= mem_rdata;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == WO_W'(LINE_WORDS-1)) begin
            tag_q[vline] <= a_tag;
            val_q[vline] <= 1'b1;
            dty_q[vline] <= 1'b0;
            ptr_q[a_idx] <= nxt(vic_q);
            state_q      <= DONE;
          end
        end
        default: begin
          cpu_ready <= 1'b1;
          cpu_rdata <= dat_q[aent];
          if (cpu_we) begin
            dat_q[aent]  <= merge(dat_q[aent]);
            dty_q[aline] <= 1'b1;
          end
          state_q <= IDLE;
        end
      endcase
    end
  end

  assert_one_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IDLE && flush) |=> (val_q == '0 && !mem_req));

  assert_miss_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 32'd1));
endmodule

// File: tb/test_cache_ctrl.sv
module test_cache_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready, mem_req, mem_we;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] hit_count, miss_count;

  always #2 clk = ~clk;

  cache_ctrl i_cache_ctrl (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [128];
  logic [31:0] ref_mem [128];
  int wr_cnt = 0, rd_cnt_op = 0;
  bit order_bad = 0, wr_after_rd = 0;
  logic [13:0] last_rd = '0;

  int          m_tag [4][2];
  bit          m_v [4][2];
  bit          m_d [4][2];
  int          m_p [4];
  logic [31:0] m_dat [4][2][4];
  int          e_hit = 0, e_miss = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req && ($urandom % 3 != 0)) begin
      if (mem_we) begin
        mem[mem_addr[6:0]] = mem_wdata;
        wr_cnt++;
        if (rd_cnt_op > 0) wr_after_rd = 1;
      end else begin
        if (rd_cnt_op == 0 && mem_addr[1:0] != 2'd0) order_bad = 1;
        if (rd_cnt_op > 0 && mem_addr != last_rd + 14'd1) order_bad = 1;
        last_rd = mem_addr;
        rd_cnt_op++;
        mem_rdata = mem[mem_addr[6:0]];
      end
      mem_ack = 1'b1;
    end
  end

  task automatic model_op(input bit we, input logic [15:0] a, input logic [31:0] wd,
                          input logic [3:0] be, output bit h, output logic [31:0] rd,
                          output int nwr);
    int ix, tg, wo, way;
    ix = int'(a[5:4]); tg = int'(a[15:6]); wo = int'(a[3:2]); way = -1;
    nwr = 0;
    for (int w = 0; w < 2; w++) if (m_v[ix][w] && m_tag[ix][w] == tg) way = w;
    if (way >= 0) begin
      h = 1; e_hit++;
      if (way == m_p[ix]) m_p[ix] = (m_p[ix] + 1) % 2;
    end else begin
      h = 0; e_miss++; way = m_p[ix];
      if (m_v[ix][way] && m_d[ix][way]) begin
        for (int k = 0; k < 4; k++) ref_mem[(m_tag[ix][way]*16 + ix*4 + k) & 127] = m_dat[ix][way][k];
        nwr = 4;
      end
      for (int k = 0; k < 4; k++) m_dat[ix][way][k] = ref_mem[(tg*16 + ix*4 + k) & 127];
      m_tag[ix][way] = tg; m_v[ix][way] = 1; m_d[ix][way] = 0;
      m_p[ix] = (way + 1) % 2;
    end
    rd = m_dat[ix][way][wo];
    if (we) begin
      for (int b = 0; b < 4; b++) if (be[b]) m_dat[ix][way][wo][8*b +: 8] = wd[8*b +: 8];
      m_d[ix][way] = 1;
    end
  endtask

  task automatic do_op(input bit we, input logic [15:0] a, input logic [31:0] wd,
                       input logic [3:0] be, input int exp_hit, input string rq);
    bit h; logic [31:0] erd; int ewr, wr0; logic [31:0] h0;
    string lab;
    model_op(we, a, wd, be, h, erd, ewr);
    lab = (rq == "") ? "R1" : rq;
    @(negedge clk);
    wr0 = wr_cnt; rd_cnt_op = 0; order_bad = 0; wr_after_rd = 0; h0 = hit_count;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    do @(negedge clk); while (!cpu_ready);
    chk(hit_count == 32'(e_hit), "R2 hit count", hit_count, 32'(e_hit));
    chk(miss_count == 32'(e_miss), "R4 miss count", miss_count, 32'(e_miss));
    if (!we) chk(cpu_rdata == erd, lab, cpu_rdata, erd);
    chk(wr_cnt - wr0 == ewr, "R6 write-back words", 32'(wr_cnt - wr0), 32'(ewr));
    chk(!wr_after_rd, "R6 write-back before fill", 32'(wr_after_rd), 0);
    if (!h) chk(!order_bad && rd_cnt_op == 4, "R4 fill order", 32'(rd_cnt_op), 4);
    if (exp_hit >= 0) chk(hit_count - h0 == 32'(exp_hit), lab, hit_count - h0, 32'(exp_hit));
    cpu_req = 0;
    @(negedge clk);
    chk(!cpu_ready, "R10 ready pulse", 32'(cpu_ready), 0);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    for (int s = 0; s < 4; s++) begin
      m_p[s] = 0;
      for (int w = 0; w < 2; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; end
    end
  endtask

  function automatic logic [15:0] mk(input int tg, input int ix, input int wo);
    return 16'(tg * 64 + ix * 16 + wo * 4);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int w0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) begin
      mem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0000;
      ref_mem[i] = mem[i];
    end
    for (int s = 0; s < 4; s++) begin
      m_p[s] = 0;
      for (int w = 0; w < 2; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; m_tag[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R10 reset idle", {30'd0, cpu_ready, mem_req}, 0);
    chk(hit_count == 0 && miss_count == 0, "R2 reset counters", hit_count | miss_count, 0);

    do_op(0, 16'h0000, 0, 0, 0, "R3");
    do_op(0, 16'h0004, 0, 0, 1, "R2");
    do_op(1, 16'h0008, 32'hDEADBEEF, 4'hF, 1, "R5");
    do_op(0, 16'h0008, 0, 0, 1, "R5");
    do_op(1, mk(3, 2, 1), 32'hA1B2C3D4, 4'b0101, 0, "R7");
    do_op(0, mk(3, 2, 1), 0, 0, 1, "R7");

    do_flush();
    do_op(1, mk(1, 1, 0), 32'h11112222, 4'hF, 0, "R8");
    do_op(0, mk(2, 1, 0), 0, 0, 0, "R8");
    do_op(0, mk(1, 1, 2), 0, 0, 1, "R8");
    do_op(1, mk(3, 1, 3), 32'h33334444, 4'hC, 0, "R8");
    do_op(0, mk(1, 1, 0), 0, 0, 1, "R8");
    do_op(0, mk(2, 1, 0), 0, 0, 0, "R8");
    do_op(0, mk(4, 1, 1), 0, 0, 0, "R6");

    do_op(1, mk(5, 3, 2), 32'hCAFEF00D, 4'hF, -1, "");
    w0 = wr_cnt;
    do_flush();
    repeat (3) @(negedge clk);
    chk(wr_cnt == w0, "R9 no write on flush", 32'(wr_cnt), 32'(w0));
    do_op(0, mk(5, 3, 2), 0, 0, 0, "R9");

    for (int n = 0; n < 700; n++) begin
      if ($urandom % 40 == 0) do_flush();
      else do_op($urandom % 2 == 1, mk($urandom % 6, $urandom % 4, $urandom % 4),
                 $urandom, 4'($urandom), -1, "");
    end

    for (int i = 0; i < 96; i++)
      if (mem[i] != ref_mem[i]) chk(0, "R6 memory image", mem[i], ref_mem[i]);
    chk(1, "R6 memory image", 0, 0);
    summary();
    $finish;
  end
endmodule